// File: doc/BRIEF.md
# Float32 invalid-result NaN selector

This block sits at the output of a single-precision arithmetic datapath and decides the final 32-bit result word when an operation reports an invalid exception. It looks at the opcode, the operands, the raw datapath result and the invalid flag. It either forwards the raw result or substitutes a fixed quiet NaN. The low fraction bits of that NaN tell the cause apart, so the source of a NaN can be traced later.

The block is purely combinational and does no arithmetic. It only classifies each operand from its exponent and fraction fields.

- The two-operand operations (add, subtract, multiply, divide) substitute a NaN only when neither operand is itself a NaN.
- The fused multiply-add and multiply-subtract operations first flush denormal operands to zero, then classify them.
- In fused operations, `a_i` and `b_i` are the multiplicands and `c_i` is the addend.

Top module: `f32_nan_select`

## Requirements
- R1: When `invalid_i` is 0, `result_o` equals `raw_i` for every opcode and operand.
- R2: For opcode 0 (add) or 1 (subtract), with `invalid_i` = 1 and neither `a_i` nor `b_i` a NaN, `result_o` is 32'h7FC00001. A NaN is a value with exponent bits [30:23] all ones and a nonzero fraction [22:0].
- R3: For opcode 2 (multiply), with `invalid_i` = 1 and neither `a_i` nor `b_i` a NaN, `result_o` is 32'h7FC00002.
- R4: For opcode 3 (divide), with `invalid_i` = 1 and neither `a_i` nor `b_i` a NaN, `result_o` is 32'h7FC00008.
- R5: For opcodes 0 to 3, with `invalid_i` = 1 and at least one of `a_i`, `b_i` a NaN, `result_o` equals `raw_i`. The value of `c_i` has no effect on opcodes 0 to 3.
- R6: For opcode 4 (multiply-add) or 5 (multiply-subtract), with `invalid_i` = 1 and any of `a_i`, `b_i`, `c_i` a NaN, `result_o` is 32'h7FC00000. This rule takes priority over R7 and R8.
- R7: For opcode 4 or 5, with `invalid_i` = 1 and no NaN present, `result_o` is 32'h7FC00002 when one multiplicand is infinite and the other is zero, in either order. An infinity has exponent all ones and a zero fraction. A value with exponent 0 counts as zero, so denormals count as zero.
- R8: For opcode 4 or 5, with `invalid_i` = 1 and neither R6 nor R7 applying, `result_o` is 32'h7FC00001 in one case. That case is: a multiplicand has exponent all ones, `c_i` has exponent all ones, and the XOR of the sign bits [31] of `a_i`, `b_i` and the effective addend sign is 1. The effective addend sign is the sign of `c_i` for opcode 4 and its inverse for opcode 5.
- R9: For opcode 4 or 5, with `invalid_i` = 1 and none of R6, R7 or R8 applying, `result_o` equals `raw_i`.
- R10: For opcodes 6 and 7, `result_o` equals `raw_i`, whatever the value of `invalid_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code: 0 add, 1 sub, 2 mul, 3 div, 4 mul-add, 5 mul-sub, 6 and 7 unused |
| invalid_i | input | 1 | Invalid exception raised by the datapath |
| a_i | input | 32 | First operand (first multiplicand for fused ops) |
| b_i | input | 32 | Second operand (second multiplicand for fused ops) |
| c_i | input | 32 | Addend for fused ops, ignored otherwise |
| raw_i | input | 32 | Raw datapath result |
| result_o | output | 32 | Final result word |

## Verification
The hardest situations to reach are the fused cases where the rules overlap:

- a denormal multiplicand paired with an infinity, which must count as a zero product;
- an infinite product against an infinite addend, whose outcome turns on the sign inversion for multiply-subtract;
- a NaN hidden among otherwise conflicting infinities, which must win over the other rules.

Random operands seldom land on these. The stimulus therefore draws each operand from weighted classes: zero, denormal, normal, infinity, quiet NaN and signalling NaN, each with a random sign. It also adds directed vectors for each overlap. Expected words come from a separate reference function written in the bench.

// File: rtl/f32_nan_select.sv
module f32_nan_select (
  input  logic [2:0]  op_i,
  input  logic        invalid_i,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [31:0] c_i,
  input  logic [31:0] raw_i,
  output logic [31:0] result_o
);

  localparam logic [31:0] QNAN_ANY = 32'h7FC0_0000;
  localparam logic [31:0] QNAN_ADD = 32'h7FC0_0001;
  localparam logic [31:0] QNAN_MUL = 32'h7FC0_0002;
  localparam logic [31:0] QNAN_DIV = 32'h7FC0_0008;

  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_MUL = 3'd2;
  localparam logic [2:0] OP_DIV = 3'd3;
  localparam logic [2:0] OP_FMA = 3'd4;
  localparam logic [2:0] OP_FMS = 3'd5;

  logic a_top, b_top, c_top;
  logic a_nan, b_nan, c_nan;
  logic a_zero, b_zero;
  logic any_nan2, any_nan3;
  logic prod_inv, inf_clash, eff_csign;

  assign a_top = &a_i[30:23];
  assign b_top = &b_i[30:23];
  assign c_top = &c_i[30:23];

  assign a_nan = a_top & (|a_i[22:0]);
  assign b_nan = b_top & (|b_i[22:0]);
  assign c_nan = c_top & (|c_i[22:0]);

  // denormals flushed: exponent zero classifies as zero
  assign a_zero = ~(|a_i[30:23]);
  assign b_zero = ~(|b_i[30:23]);

  assign any_nan2 = a_nan | b_nan;
  assign any_nan3 = any_nan2 | c_nan;

  assign prod_inv  = (a_top & b_zero) | (a_zero & b_top);
  assign eff_csign = c_i[31] ^ (op_i == OP_FMS);
  assign inf_clash = (a_top | b_top) & c_top & (a_i[31] ^ b_i[31] ^ eff_csign);

  always_comb begin
    result_o = raw_i;
    if (invalid_i) begin
      unique case (op_i)
        OP_ADD, OP_SUB: if (!any_nan2) result_o = QNAN_ADD;
        OP_MUL:         if (!any_nan2) result_o = QNAN_MUL;
        OP_DIV:         if (!any_nan2) result_o = QNAN_DIV;
        OP_FMA, OP_FMS: begin
          if (any_nan3)       result_o = QNAN_ANY;
          else if (prod_inv)  result_o = QNAN_MUL;
          else if (inf_clash) result_o = QNAN_ADD;
        end
        default: result_o = raw_i;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({op_i, invalid_i, a_i, b_i, c_i, raw_i, result_o})) begin
      p_pass_clean_r1: assert (invalid_i || result_o == raw_i);
      p_spare_op_r10: assert (op_i < 3'd6 || result_o == raw_i);
      p_div_code_r4: assert (!(invalid_i && op_i == OP_DIV && !a_nan && !b_nan)
                             || result_o == QNAN_DIV);
      p_nan_wins_r6: assert (!(invalid_i && (op_i == OP_FMA || op_i == OP_FMS)
                               && (a_nan || b_nan || c_nan))
                             || result_o == QNAN_ANY);
      p_only_nans_r5: assert (result_o == raw_i || result_o[31:23] == 9'h0FF);
    end
  end

endmodule

// File: tb/f32_nan_select_tb.sv
module f32_nan_select_tb;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [2:0]  op;
  logic        inv;
  logic [31:0] a, b, c, raw;
  logic [31:0] res;
  int          n_run = 0;
  int          n_fail = 0;
  string       tag;

  always #(PERIOD/2) clk = ~clk;

  f32_nan_select u_dut (
    .op_i(op), .invalid_i(inv), .a_i(a), .b_i(b), .c_i(c),
    .raw_i(raw), .result_o(res)
  );

  function automatic bit m_nan(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit m_inf(input logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] == 0);
  endfunction

  function automatic logic [31:0] model(input logic [2:0] o, input logic v,
      input logic [31:0] x, input logic [31:0] y, input logic [31:0] z,
      input logic [31:0] r, output string t);
    logic s;
    t = "R1";
    if (!v) return r;
    if (o >= 3'd6) begin t = "R10"; return r; end
    if (o < 3'd4) begin
      if (m_nan(x) || m_nan(y)) begin t = "R5"; return r; end
      if (o == 3'd2) begin t = "R3"; return 32'h7FC00002; end
      if (o == 3'd3) begin t = "R4"; return 32'h7FC00008; end
      t = "R2"; return 32'h7FC00001;
    end
    if (m_nan(x) || m_nan(y) || m_nan(z)) begin t = "R6"; return 32'h7FC00000; end
    if ((m_inf(x) && y[30:23] == 0) || (m_inf(y) && x[30:23] == 0)) begin
      t = "R7"; return 32'h7FC00002;
    end
    s = z[31] ^ (o == 3'd5);
    if ((m_inf(x) || m_inf(y)) && m_inf(z) && (x[31] ^ y[31] ^ s)) begin
      t = "R8"; return 32'h7FC00001;
    end
    t = "R9"; return r;
  endfunction

  function automatic logic [31:0] gen(input int cls);
    logic [31:0] v;
    logic sg;
    sg = 1'($urandom);
    case (cls)
      0: v = {sg, 31'd0};
      1: v = {sg, 8'd0, 23'($urandom | 1)};
      2: v = {sg, 8'($urandom % 254 + 1), 23'($urandom)};
      3: v = {sg, 8'hFF, 23'd0};
      4: v = {sg, 8'hFF, 1'b1, 22'($urandom)};
      default: v = {sg, 8'hFF, 1'b0, 22'($urandom | 1)};
    endcase
    return v;
  endfunction

  task automatic run(input logic [2:0] o, input logic v, input logic [31:0] x,
                     input logic [31:0] y, input logic [31:0] z, input logic [31:0] r);
    logic [31:0] exp_v;
    @(negedge clk);
    op = o; inv = v; a = x; b = y; c = z; raw = r;
    @(posedge clk);
    exp_v = model(o, v, x, y, z, r, tag);
    n_run++;
    if (res !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d inv=%0b a=%h b=%h c=%h actual=%h expected=%h",
               tag, o, v, x, y, z, res, exp_v);
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    op = 0; inv = 0; a = 0; b = 0; c = 0; raw = 0;
    // R1 no invalid
    run(3'd2, 1'b0, 32'h7F800000, 32'h0, 32'h0, 32'h12345678);
    // R2 add/sub inf-inf
    run(3'd0, 1'b1, 32'h7F800000, 32'hFF800000, 32'h0, 32'hDEADBEEF);
    run(3'd1, 1'b1, 32'h7F800000, 32'h7F800000, 32'h7FC00000, 32'hDEADBEEF);
    // R3 mul
    run(3'd2, 1'b1, 32'h00000000, 32'hFF800000, 32'h0, 32'h1);
    // R4 div
    run(3'd3, 1'b1, 32'h00000000, 32'h80000000, 32'h0, 32'h2);
    // R5 NaN operand
    run(3'd0, 1'b1, 32'h7F800001, 32'h3F800000, 32'h0, 32'hCAFEF00D);
    run(3'd3, 1'b1, 32'h3F800000, 32'hFFC00000, 32'h0, 32'hCAFEF00D);
    // R6 NaN wins over clash
    run(3'd4, 1'b1, 32'h7F800000, 32'h0, 32'h7FA00000, 32'h5);
    // R7 inf times denormal, both orders
    run(3'd4, 1'b1, 32'h00000001, 32'hFF800000, 32'h3F800000, 32'h6);
    run(3'd5, 1'b1, 32'h7F800000, 32'h807FFFFF, 32'h3F800000, 32'h6);
    // R8 sign clash, inversion for msub
    run(3'd4, 1'b1, 32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h7);
    run(3'd5, 1'b1, 32'h7F800000, 32'h3F800000, 32'h7F800000, 32'h7);
    // R9 same signs, no clash
    run(3'd5, 1'b1, 32'h7F800000, 32'h3F800000, 32'hFF800000, 32'h8);
    run(3'd4, 1'b1, 32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h9);
    // R10 spare opcodes
    run(3'd6, 1'b1, 32'h7F800000, 32'h0, 32'h0, 32'hA);
    run(3'd7, 1'b1, 32'h0, 32'h0, 32'h0, 32'hB);
    for (int i = 0; i < 3000; i++) begin
      automatic int ca = $urandom % 6;
      automatic int cb = $urandom % 6;
      automatic int cc = $urandom % 6;
      run(3'($urandom), ($urandom % 4) != 0, gen(ca), gen(cb), gen(cc), $urandom);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule